// File: doc/BRIEF.md
# Read Delay Calibration Engine

This block tunes the read-capture delay of a DDR memory interface. On a start request it steps a delay code upward from zero. For each code it first programs that code into the interface control register. It then fills a block of memory with a fixed set of test words and reads every word back several times. A code passes only when every read returns the word that was written.

The engine keeps the lowest passing code. Failing codes seen before that first pass have no effect on the result. The first failing code after a pass ends the sweep, and the code just below it becomes the upper edge of the window. If the sweep reaches the top code without such a failure, the upper edge is the top code. The engine then programs the centre of the window and reports it with a one-cycle done pulse. If no code ever passes, it programs code zero and raises an error flag.

The memory side is a single request port: a request stays asserted until the memory acknowledges it. The control register side is a single-cycle write strobe with a data word.

Top module: `rdc_engine`

## Requirements
- R1: After reset, done_o, error_o, cfg_we_o and mem_req_o are 0, result_o is 0, and a control write never occurs in the same cycle as a memory request.
- R2: After start_i, the sweep writes delay codes 0, 1, 2, ... in ascending order, one control write per code. Each control word is 0x80800800 OR the code in the low DLY_W bits.
- R3: For each code, the engine writes words 0 to NUM_WORDS-1 to addresses 0 to NUM_WORDS-1. Word j is A(j[5:4]) XOR all-ones when j[1] XOR j[3] is 1, otherwise A(j[5:4]). A = 0x00000000, 0xAAAAAAAA, 0xA5A5A5A5, 0xAA55AA55 for j[5:4] = 0, 1, 2, 3.
- R4: Each word is read NUM_READS times and every read is compared. A mismatch on any read, including the last read of the last word, fails the code at once.
- R5: The lowest passing code is kept as the lower edge. Failing codes below it do not affect the result.
- R6: The first failing code after a pass ends the sweep: no higher code is written, and the upper edge is that code minus 1.
- R7: If no failure follows the first pass, the upper edge is the top code 2^DLY_W-1.
- R8: At the end, the engine writes 0x80800800 OR floor((lower+upper)/2). One cycle later done_o pulses for exactly one cycle, with result_o equal to that code and error_o low.
- R9: If no code passes, the final control word is 0x80800800 with code 0, and the done pulse carries result_o = 0 with error_o = 1.
- R10: Once mem_req_o is raised, it stays high with address, direction and write data unchanged until the cycle in which mem_ack_i is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a calibration run when idle |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| error_o | output | 1 | Set when no delay code passed; held until the next start |
| result_o | output | DLY_W | Chosen delay code, held until the next start |
| cfg_we_o | output | 1 | Control register write strobe |
| cfg_wdata_o | output | 32 | Control register write data |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write request, 0 = read request |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ack_i | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata_i | input | DATA_W | Read data |

## Verification
The bench builds the engine with DLY_W = 5, NUM_WORDS = 64 and NUM_READS = 2. The narrow delay code keeps a full 32-step sweep short enough for several complete runs: windows at the bottom, in the middle and at the top of the range, a full-range pass, no pass at all, and an isolated passing code below the main window. Keeping all 64 words exercises all four pattern groups. Two reads per word are enough for a memory model that corrupts only the final repeat of the final word, which proves that every repeat is compared.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CFG,
      ST_WR,
      ST_RD,
      ST_EVAL,
      ST_FINAL
   } rdc_state_e;

   localparam int unsigned PAT_IDX_MIN = 6;
endpackage

// File: rtl/rdc_pattern.sv
module rdc_pattern #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 6
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] word
);
   localparam int unsigned HALVES = DATA_W / 16;

   logic [15:0] base_half;
   logic        invert;

   always_comb begin
      unique case (idx[5:4])
         2'd0: base_half = 16'h0000;
         2'd1: base_half = 16'hAAAA;
         2'd2: base_half = 16'hA5A5;
         default: base_half = 16'hAA55;
      endcase
   end

   // word pairs alternate in runs of two, with the run order flipped in the upper half of each group
   assign invert = idx[1] ^ idx[3];

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      assign word[h*16 +: 16] = base_half ^ {16{invert}};
   end
endmodule

// File: rtl/rdc_window.sv
module rdc_window #(
   parameter int unsigned DLY_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             upd,
   input  logic             pass,
   input  logic [DLY_W-1:0] dly,
   output logic             found,
   output logic [DLY_W-1:0] mid
);
   logic [DLY_W-1:0] lo_q;
   logic [DLY_W-1:0] hi_q;
   logic [DLY_W:0]   sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         found <= 1'b0;
         lo_q  <= '0;
         hi_q  <= '1;
      end else if (clr) begin
         found <= 1'b0;
         lo_q  <= '0;
         hi_q  <= '1;
      end else if (upd) begin
         if (pass && !found) begin
            found <= 1'b1;
            lo_q  <= dly;
         end else if (!pass && found) begin
            hi_q <= dly - 1'b1;
         end
      end
   end

   assign sum = {1'b0, lo_q} + {1'b0, hi_q};
   assign mid = sum[DLY_W:1];
endmodule

// File: rtl/rdc_engine.sv
module rdc_engine #(
   parameter int unsigned DLY_W     = 9,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_WORDS = 64,
   parameter int unsigned NUM_READS = 10,
   parameter int unsigned CTRL_W    = 32,
   parameter logic [31:0] CTRL_BASE = 32'h8080_0800,
   localparam int unsigned ADDR_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              done_o,
   output logic              error_o,
   output logic [DLY_W-1:0]  result_o,
   output logic              cfg_we_o,
   output logic [CTRL_W-1:0] cfg_wdata_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic              mem_ack_i,
   input  logic [DATA_W-1:0] mem_rdata_i
);
   import rdc_pkg::*;

   localparam int unsigned REP_W = (NUM_READS > 1) ? $clog2(NUM_READS) : 1;
   localparam int unsigned IDX_W = (ADDR_W > PAT_IDX_MIN) ? ADDR_W : PAT_IDX_MIN;
   localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_WORDS - 1);
   localparam logic [REP_W-1:0]  LAST_REP = REP_W'(NUM_READS - 1);
   localparam logic [DLY_W-1:0]  DLY_MAX  = '1;

   if (DATA_W == 0 || DATA_W % 16 != 0) begin : g_bad_data
      $error("DATA_W must be a nonzero multiple of 16");
   end
   if (DLY_W < 1 || DLY_W > 11) begin : g_bad_dly
      $error("DLY_W must be 1..11 to stay below the control base bits");
   end
   if (NUM_WORDS < 1 || NUM_READS < 1) begin : g_bad_cnt
      $error("NUM_WORDS and NUM_READS must be at least 1");
   end
   if (CTRL_W < 32) begin : g_bad_ctrl
      $error("CTRL_W must hold the 32-bit control word");
   end

   rdc_state_e        state;
   logic [DLY_W-1:0]  dly;
   logic [ADDR_W-1:0] idx;
   logic [REP_W-1:0]  rep;
   logic              pass_q;
   logic [DLY_W-1:0]  result_q;
   logic              error_q;
   logic              done_q;

   logic [DATA_W-1:0] exp_word;
   logic              win_found;
   logic [DLY_W-1:0]  win_mid;
   logic [DLY_W-1:0]  final_code;
   logic              win_clr;
   logic              win_upd;

   rdc_pattern #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_pattern (
      .idx  (IDX_W'(idx)),
      .word (exp_word)
   );

   rdc_window #(.DLY_W(DLY_W)) i_window (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (win_clr),
      .upd   (win_upd),
      .pass  (pass_q),
      .dly   (dly),
      .found (win_found),
      .mid   (win_mid)
   );

   assign win_clr    = (state == ST_IDLE) && start_i;
   assign win_upd    = (state == ST_EVAL);
   assign final_code = win_found ? win_mid : '0;

   always_comb begin
      cfg_we_o    = 1'b0;
      cfg_wdata_o = '0;
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = idx;
      mem_wdata_o = '0;
      unique case (state)
         ST_CFG: begin
            cfg_we_o    = 1'b1;
            cfg_wdata_o = CTRL_W'(CTRL_BASE) | CTRL_W'(dly);
         end
         ST_WR: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_wdata_o = exp_word;
         end
         ST_RD: mem_req_o = 1'b1;
         ST_FINAL: begin
            cfg_we_o    = 1'b1;
            cfg_wdata_o = CTRL_W'(CTRL_BASE) | CTRL_W'(final_code);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         dly      <= '0;
         idx      <= '0;
         rep      <= '0;
         pass_q   <= 1'b0;
         result_q <= '0;
         error_q  <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start_i) begin
                  dly      <= '0;
                  result_q <= '0;
                  error_q  <= 1'b0;
                  state    <= ST_CFG;
               end
            end
            ST_CFG: begin
               idx   <= '0;
               rep   <= '0;
               state <= ST_WR;
            end
            ST_WR: begin
               if (mem_ack_i) begin
                  if (idx == LAST_IDX) begin
                     idx   <= '0;
                     state <= ST_RD;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            ST_RD: begin
               if (mem_ack_i) begin
                  if (mem_rdata_i != exp_word) begin
                     pass_q <= 1'b0;
                     state  <= ST_EVAL;
                  end else if (rep == LAST_REP) begin
                     rep <= '0;
                     if (idx == LAST_IDX) begin
                        pass_q <= 1'b1;
                        state  <= ST_EVAL;
                     end else begin
                        idx <= idx + 1'b1;
                     end
                  end else begin
                     rep <= rep + 1'b1;
                  end
               end
            end
            ST_EVAL: begin
               if ((!pass_q && win_found) || dly == DLY_MAX) begin
                  state <= ST_FINAL;
               end else begin
                  dly   <= dly + 1'b1;
                  state <= ST_CFG;
               end
            end
            ST_FINAL: begin
               result_q <= final_code;
               error_q  <= !win_found;
               done_q   <= 1'b1;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign done_o   = done_q;
   assign error_o  = error_q;
   assign result_o = result_q;
endmodule

// File: rtl/rdc_engine_chk.sv
module rdc_engine_chk #(
   parameter int unsigned DLY_W  = 9,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned CTRL_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done_o,
   input logic              error_o,
   input logic [DLY_W-1:0]  result_o,
   input logic              cfg_we_o,
   input logic              mem_req_o,
   input logic              mem_we_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [DATA_W-1:0] mem_wdata_o,
   input logic              mem_ack_i
);
   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                  && $stable(mem_we_o) && $stable(mem_wdata_o));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_after_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(cfg_we_o));

   // R9
   error_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && error_o |-> result_o == '0);

   // R1
   port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we_o |-> !mem_req_o);
endmodule

bind rdc_engine rdc_engine_chk #(
   .DLY_W  (DLY_W),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .CTRL_W (CTRL_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .done_o      (done_o),
   .error_o     (error_o),
   .result_o    (result_o),
   .cfg_we_o    (cfg_we_o),
   .mem_req_o   (mem_req_o),
   .mem_we_o    (mem_we_o),
   .mem_addr_o  (mem_addr_o),
   .mem_wdata_o (mem_wdata_o),
   .mem_ack_i   (mem_ack_i)
);

// File: tb/test_rdc_engine.sv
module test_rdc_engine;
   localparam int DLY_W = 5;
   localparam int NW    = 64;
   localparam int NR    = 2;
   localparam int DMAX  = (1 << DLY_W) - 1;
   localparam logic [31:0] BASE = 32'h8080_0800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        done_o, error_o, cfg_we_o, mem_req_o, mem_we_o;
   logic [DLY_W-1:0] result_o;
   logic [31:0] cfg_wdata_o, mem_wdata_o;
   logic [5:0]  mem_addr_o;
   logic        mem_ack_i = 1'b0;
   logic [31:0] mem_rdata_i = '0;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // memory model state
   logic [31:0] mem [NW];
   int lo_w, hi_w, extra_w;
   bit late_w;
   int cur_dly, rd_cnt, wr_err, cfg_n;
   logic [31:0] cfg_log [64];

   always #5 clk = ~clk;

   rdc_engine #(.DLY_W(DLY_W), .DATA_W(32), .NUM_WORDS(NW), .NUM_READS(NR)) i_rdc_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o), .error_o(error_o),
      .result_o(result_o), .cfg_we_o(cfg_we_o), .cfg_wdata_o(cfg_wdata_o),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i));

   function automatic logic [31:0] ref_word(int j);
      logic [31:0] a;
      int pos;
      case (j / 16)
         0: a = 32'h0000_0000;
         1: a = 32'hAAAA_AAAA;
         2: a = 32'hA5A5_A5A5;
         default: a = 32'hAA55_AA55;
      endcase
      pos = j % 16;
      if (pos == 2 || pos == 3 || pos == 6 || pos == 7 || pos == 8 || pos == 9 ||
          pos == 12 || pos == 13) a = ~a;
      return a;
   endfunction

   function automatic bit dly_ok(int d);
      return (d >= lo_w && d <= hi_w) || d == extra_w;
   endfunction

   always @(posedge clk) begin
      mem_ack_i <= 1'b0;
      if (cfg_we_o) begin
         if (cfg_n < 64) cfg_log[cfg_n] <= cfg_wdata_o;
         cfg_n   <= cfg_n + 1;
         cur_dly <= int'(cfg_wdata_o[DLY_W-1:0]);
         rd_cnt  <= 0;
      end
      if (mem_req_o && !mem_ack_i) begin
         mem_ack_i <= 1'b1;
         if (mem_we_o) begin
            mem[mem_addr_o] <= mem_wdata_o;
            if (mem_wdata_o != ref_word(int'(mem_addr_o))) wr_err <= wr_err + 1;
         end else begin
            rd_cnt <= rd_cnt + 1;
            if (!dly_ok(cur_dly) && (!late_w || rd_cnt == NW*NR-1))
               mem_rdata_i <= mem[mem_addr_o] ^ 32'h1;
            else
               mem_rdata_i <= mem[mem_addr_o];
         end
      end
   end

   task automatic chk(bit ok, string req, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic test_reset();
      @(negedge clk);
      chk(done_o == 0 && error_o == 0, "R1 flags", {done_o, error_o}, 0);
      chk(cfg_we_o == 0 && mem_req_o == 0, "R1 strobes", {cfg_we_o, mem_req_o}, 0);
      chk(result_o == 0, "R1 result", result_o, 0);
   endtask

   // one full calibration run against a window model; the expected outcome is derived here
   task automatic run_case(string tag, int lo, int hi, int extra, bit late);
      int first, last, nsweep, cyc, exp_res;
      bit seq_ok, got_done;
      lo_w = lo; hi_w = hi; extra_w = extra; late_w = late;
      first = -1; last = DMAX; nsweep = DMAX + 1;
      for (int d = 0; d <= DMAX; d++) begin
         if (dly_ok(d)) begin
            if (first < 0) first = d;
         end else if (first >= 0) begin
            last = d - 1; nsweep = d + 1; break;
         end
      end
      exp_res = (first < 0) ? 0 : (first + last) / 2;
      @(negedge clk);
      cfg_n = 0; wr_err = 0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      got_done = 0;
      for (cyc = 0; cyc < 30000; cyc++) begin
         @(negedge clk);
         if (done_o) begin got_done = 1; break; end
      end
      chk(got_done, {tag, " R8 done"}, got_done, 1);
      chk(result_o == DLY_W'(exp_res), {tag, " R5 R7 R8 result"}, result_o, exp_res);
      chk(error_o == (first < 0), {tag, " R9 error"}, error_o, first < 0);
      chk(cfg_n == nsweep + 1, {tag, " R6 sweep length"}, cfg_n, nsweep + 1);
      seq_ok = 1;
      for (int i = 0; i < nsweep && i < 64; i++)
         if (cfg_log[i] != (BASE | 32'(i))) seq_ok = 0;
      chk(seq_ok, {tag, " R2 sweep words"}, seq_ok, 1);
      if (cfg_n >= 1 && cfg_n <= 64)
         chk(cfg_log[cfg_n-1] == (BASE | 32'(exp_res)), {tag, " R8 final word"},
             cfg_log[cfg_n-1], BASE | 32'(exp_res));
      chk(wr_err == 0, {tag, " R3 pattern"}, wr_err, 0);
      @(negedge clk);
      chk(done_o == 0, {tag, " R8 pulse width"}, done_o, 0);
   endtask

   task automatic test_mid_window();  run_case("mid R5", 8, 20, -1, 0);   endtask
   task automatic test_full_pass();   run_case("full R7", 0, DMAX, -1, 0); endtask
   task automatic test_top_window();  run_case("top R5 R7", 25, DMAX, -1, 0); endtask
   task automatic test_no_pass();     run_case("none R9", DMAX, 0, -1, 0); endtask
   task automatic test_late_fail();   run_case("late R4", 4, 9, -1, 1);   endtask
   task automatic test_isolated();    run_case("isolated R6", 10, 20, 3, 0); endtask

   initial begin
      cfg_n = 0; wr_err = 0; cur_dly = 0; rd_cnt = 0;
      lo_w = 0; hi_w = DMAX; extra_w = -1; late_w = 0;
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      test_reset();
      test_mid_window();
      test_full_pass();
      test_top_window();
      test_no_pass();
      test_late_fail();
      test_isolated();
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule